// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

The block divides one IEEE-754 single-precision operand by another over a fixed number of clock cycles. The dividend arrives on `dvnd_i` and the divisor on `dvsr_i`; a one-cycle `start` pulse captures both. The quotient `dvnd_i / dvsr_i` appears on `result` together with a one-cycle `done` pulse, exactly a mode-dependent number of cycles later. The count does not depend on the operands.

Both operands are classified on the start cycle. Denormal inputs are rejected, and invalid operations and quiet NaNs produce one fixed quiet-NaN word. Zero and infinite operands are resolved without arithmetic. Finite normal operands go through a restoring mantissa divider that produces one or two quotient bits per cycle. The quotient is rounded to nearest-even and then checked for range.

Every exceptional outcome pulses `exc_valid` with a fixed 5-bit code and holds back `wr_en`, so a destination register would keep its old value. Five sticky status bits record what has happened until software-level logic pulses `clr_flags`.

Top module: `fp_quot_seq`

## Requirements
- R1: For finite normal operands whose rounded quotient is in the normal range, `result` is `dvnd_i / dvsr_i` rounded to nearest-even, with sign equal to the XOR of the operand signs; `wr_en` pulses with `done` and `exc_valid` stays low.
- R2: If either operand is denormal (exponent field 0, fraction non-zero), `result` is 32'hFFC00000, status bit 4 (denormal-operand) is set and an exception is raised.
- R3: If either operand is a signaling NaN (exponent 255, fraction non-zero, fraction bit 22 clear), or both are zero, or both are infinite, `result` is 32'hFFC00000, status bit 0 (invalid) is set and an exception is raised.
- R4: A quiet NaN operand (exponent 255, fraction bit 22 set) gives 32'hFFC00000 with `wr_en` asserted, no status bit set and no exception.
- R5: A zero divisor with a dividend that is neither zero nor infinite gives infinity with the XOR sign, sets status bit 1 (divide-by-zero) and raises an exception.
- R6: A rounded quotient whose biased exponent would be 0 or below gives a zero with the quotient's sign, sets status bit 3 (underflow) and raises an exception.
- R7: A rounded quotient whose biased exponent would be 255 or above gives infinity with the quotient's sign, sets status bit 2 (overflow) and raises an exception.
- R8: When an exception is raised, `exc_valid` pulses with `done`, `exc_code` is 5'b00110 and `wr_en` stays low. At all other times `exc_code` is 0.
- R9: `done` is a one-cycle pulse exactly LAT clock edges after the edge that accepted `start`, where LAT is 28 for `LAT_MODE`=0, 30 for 1 and 24 for 2.
- R10: The cases are decided in the priority order denormal, invalid, quiet NaN, divide-by-zero, underflow, overflow, normal.
- R11: Status bits are sticky. A completion ORs in its bits, and a `clr_flags` pulse zeroes them. They change at no other time.
- R12: A `start` pulse while an operation is in flight is ignored. The running operation keeps its operands and its completion time.
- R13: An infinite dividend over a finite divisor gives signed infinity. A finite dividend over an infinite divisor, or a zero dividend over a non-zero finite divisor, gives signed zero. None of these raises an exception.
- R14: After reset, `done`, `wr_en`, `exc_valid`, `exc_code`, `status` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| dvsr_i | input | 32 | Divisor, single precision |
| dvnd_i | input | 32 | Dividend, single precision |
| clr_flags | input | 1 | Zero the sticky status bits |
| done | output | 1 | Completion pulse |
| result | output | 32 | Quotient or special value |
| wr_en | output | 1 | Destination write strobe (low on exception) |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | EXC_W | Exception code while `exc_valid` |
| status | output | 5 | Sticky bits: 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 denormal-operand |

## Verification
The bench builds three copies side by side with `LAT_MODE` 2, 0 and 1. This covers the two-bit-per-cycle divider at 24 cycles and the one-bit divider at 28 and 30 cycles, with each latency checked against the same stimulus. The operand width is fixed, so the sweep runs every ordered pair from a set of thirteen special and boundary encodings, which covers every priority collision. It also runs several hundred random normal pairs, both with full-range exponents (reaching overflow and underflow) and with exponents near the bias (exercising rounding carries). Each result is compared with a reference built from double-precision real division, rounded to 24 bits in the bench.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
   localparam int SP_W   = 32;
   localparam int EXP_W  = 8;
   localparam int FRAC_W = 23;
   localparam int MANT_W = FRAC_W + 1;
   localparam int SE_W   = EXP_W + 2;
   localparam int BIAS   = 127;
   localparam logic [SP_W-1:0] NAN_WORD = 32'hFFC00000;

   localparam int FL_N   = 5;
   localparam int FL_INV = 0;
   localparam int FL_DZ  = 1;
   localparam int FL_OF  = 2;
   localparam int FL_UF  = 3;
   localparam int FL_DEN = 4;

   typedef struct packed {
      logic             arith;
      logic             exc;
      logic [FL_N-1:0]  flags;
      logic [SP_W-1:0]  value;
   } pre_t;

   function automatic int lat_for_mode(input int mode);
      case (mode)
         1:       return 30;
         2:       return 24;
         default: return 28;
      endcase
   endfunction
endpackage

// File: rtl/fpd_classify.sv
module fpd_classify
   import fpd_pkg::*;
(
   input  logic [SP_W-1:0] dvsr,
   input  logic [SP_W-1:0] dvnd,
   output pre_t            pre
);
   logic [EXP_W-1:0]  ex_s, ex_d;
   logic [FRAC_W-1:0] fr_s, fr_d;
   logic s_den, d_den, s_zero, d_zero, s_inf, d_inf;
   logic s_nan, d_nan, s_qn, d_qn, s_sn, d_sn, sq;

   always_comb begin
      ex_s   = dvsr[SP_W-2 -: EXP_W];
      ex_d   = dvnd[SP_W-2 -: EXP_W];
      fr_s   = dvsr[FRAC_W-1:0];
      fr_d   = dvnd[FRAC_W-1:0];
      sq     = dvsr[SP_W-1] ^ dvnd[SP_W-1];
      s_den  = (ex_s == '0) && (fr_s != '0);
      d_den  = (ex_d == '0) && (fr_d != '0);
      s_zero = (ex_s == '0) && (fr_s == '0);
      d_zero = (ex_d == '0) && (fr_d == '0);
      s_inf  = (ex_s == '1) && (fr_s == '0);
      d_inf  = (ex_d == '1) && (fr_d == '0);
      s_nan  = (ex_s == '1) && (fr_s != '0);
      d_nan  = (ex_d == '1) && (fr_d != '0);
      s_qn   = s_nan &&  fr_s[FRAC_W-1];
      d_qn   = d_nan &&  fr_d[FRAC_W-1];
      s_sn   = s_nan && !fr_s[FRAC_W-1];
      d_sn   = d_nan && !fr_d[FRAC_W-1];

      pre = '0;
      if (s_den || d_den) begin
         pre.value        = NAN_WORD;
         pre.flags[FL_DEN] = 1'b1;
         pre.exc          = 1'b1;
      end else if (s_sn || d_sn || (s_zero && d_zero) || (s_inf && d_inf)) begin
         pre.value        = NAN_WORD;
         pre.flags[FL_INV] = 1'b1;
         pre.exc          = 1'b1;
      end else if (s_qn || d_qn) begin
         pre.value        = NAN_WORD;
      end else if (s_zero && !d_inf) begin
         pre.value        = {sq, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
         pre.flags[FL_DZ]  = 1'b1;
         pre.exc          = 1'b1;
      end else if (d_inf) begin
         pre.value        = {sq, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (s_inf || d_zero) begin
         pre.value        = {sq, {(SP_W-1){1'b0}}};
      end else begin
         pre.arith        = 1'b1;
      end
   end
endmodule

// File: rtl/fpd_divcore.sv
module fpd_divcore
   import fpd_pkg::*;
#(
   parameter int RB  = 1,
   parameter int Q_W = 27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [MANT_W-1:0] num,
   input  logic [MANT_W-1:0] den,
   output logic [Q_W-1:0]    quo,
   output logic              rem_nz
);
   logic [MANT_W:0]   rem_q;
   logic [MANT_W-1:0] den_q;
   logic [RB-1:0]     qbits;
   logic [MANT_W:0]   rem_next;

   for (genvar i = 0; i < RB; i++) begin : g_stage
      logic [MANT_W:0] r_in, r_out, diff;
      logic            ge;
      if (i == 0) begin : g_first
         assign r_in = rem_q;
      end else begin : g_next
         assign r_in = g_stage[i-1].r_out;
      end
      assign ge          = r_in >= {1'b0, den_q};
      assign diff        = ge ? (r_in - {1'b0, den_q}) : r_in;
      assign r_out       = {diff[MANT_W-1:0], 1'b0};
      assign qbits[RB-1-i] = ge;
   end
   assign rem_next = g_stage[RB-1].r_out;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         quo   <= '0;
      end else if (load) begin
         rem_q <= {1'b0, num};
         den_q <= den;
         quo   <= '0;
      end else if (step) begin
         rem_q <= rem_next;
         quo   <= {quo[Q_W-RB-1:0], qbits};
      end
   end

   assign rem_nz = (rem_q != '0);
endmodule

// File: rtl/fpd_round.sv
module fpd_round
   import fpd_pkg::*;
#(
   parameter int Q_W = 27
) (
   input  logic [Q_W-1:0]         quo,
   input  logic                   rem_nz,
   input  logic signed [SE_W-1:0] e_in,
   input  logic                   sign,
   output logic [SP_W-1:0]        value,
   output logic                   uf,
   output logic                   of
);
   logic [MANT_W-1:0]      man;
   logic                   grd, stk;
   logic signed [SE_W-1:0] e_n, e_r;
   logic [MANT_W:0]        sum;

   always_comb begin
      if (quo[Q_W-1]) begin
         man = quo[Q_W-1 -: MANT_W];
         grd = quo[Q_W-1-MANT_W];
         stk = (|quo[Q_W-2-MANT_W:0]) | rem_nz;
         e_n = e_in;
      end else begin
         man = quo[Q_W-2 -: MANT_W];
         grd = quo[Q_W-2-MANT_W];
         stk = (|quo[Q_W-3-MANT_W:0]) | rem_nz;
         e_n = e_in - SE_W'(1);
      end
      sum = {1'b0, man} + {{MANT_W{1'b0}}, grd & (stk | man[0])};
      e_r = sum[MANT_W] ? (e_n + SE_W'(1)) : e_n;
      uf  = (e_r <= 0);
      of  = (e_r >= SE_W'((1 << EXP_W) - 1));
      if (uf)
         value = {sign, {(SP_W-1){1'b0}}};
      else if (of)
         value = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
         value = {sign, e_r[EXP_W-1:0], sum[FRAC_W-1:0]};
   end
endmodule

// File: rtl/fp_quot_seq.sv
module fp_quot_seq
   import fpd_pkg::*;
#(
   parameter int               LAT_MODE = 0,
   parameter int               EXC_W    = 5,
   parameter logic [EXC_W-1:0] EXC_CODE = 5'b00110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SP_W-1:0]  dvsr_i,
   input  logic [SP_W-1:0]  dvnd_i,
   input  logic             clr_flags,
   output logic             done,
   output logic [SP_W-1:0]  result,
   output logic             wr_en,
   output logic             exc_valid,
   output logic [EXC_W-1:0] exc_code,
   output logic [FL_N-1:0]  status
);
   localparam int LAT        = lat_for_mode(LAT_MODE);
   localparam int RADIX_BITS = (LAT_MODE == 2) ? 2 : 1;
   localparam int Q_MIN      = MANT_W + 3;
   localparam int ITER       = (Q_MIN + RADIX_BITS - 1) / RADIX_BITS;
   localparam int Q_W        = ITER * RADIX_BITS;
   localparam int CNT_W      = $clog2(LAT + 1);

   if (LAT_MODE < 0 || LAT_MODE > 2) begin : g_bad_mode
      $error("fp_quot_seq: LAT_MODE must be 0, 1 or 2");
   end
   if (ITER >= LAT) begin : g_bad_iter
      $error("fp_quot_seq: divider iterations do not fit the latency");
   end
   if (EXC_W < 1) begin : g_bad_exc
      $error("fp_quot_seq: EXC_W must be positive");
   end

   logic                   busy;
   logic [CNT_W-1:0]       cnt;
   pre_t                   pre_c, pre_r;
   logic signed [SE_W-1:0] ed_r;
   logic                   sgn_r;
   logic                   load, step;
   logic [Q_W-1:0]         quo;
   logic                   rem_nz;
   logic [SP_W-1:0]        arith_val, fin_val;
   logic                   a_uf, a_of, fin_exc;
   logic [FL_N-1:0]        fin_fl, fl_base;

   assign load    = start && !busy;
   assign step    = busy && (cnt <= CNT_W'(ITER));
   assign fl_base = clr_flags ? '0 : status;

   fpd_classify u_cls (
      .dvsr (dvsr_i),
      .dvnd (dvnd_i),
      .pre  (pre_c)
   );

   fpd_divcore #(.RB(RADIX_BITS), .Q_W(Q_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .num    ({1'b1, dvnd_i[FRAC_W-1:0]}),
      .den    ({1'b1, dvsr_i[FRAC_W-1:0]}),
      .quo    (quo),
      .rem_nz (rem_nz)
   );

   fpd_round #(.Q_W(Q_W)) u_rnd (
      .quo    (quo),
      .rem_nz (rem_nz),
      .e_in   (ed_r),
      .sign   (sgn_r),
      .value  (arith_val),
      .uf     (a_uf),
      .of     (a_of)
   );

   always_comb begin
      fin_fl = '0;
      if (pre_r.arith) begin
         fin_val        = arith_val;
         fin_fl[FL_UF]  = a_uf;
         fin_fl[FL_OF]  = a_of;
         fin_exc        = a_uf | a_of;
      end else begin
         fin_val        = pre_r.value;
         fin_fl         = pre_r.flags;
         fin_exc        = pre_r.exc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt       <= '0;
         pre_r     <= '0;
         ed_r      <= '0;
         sgn_r     <= 1'b0;
         done      <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         exc_valid <= 1'b0;
         exc_code  <= '0;
         status    <= '0;
      end else begin
         done      <= 1'b0;
         wr_en     <= 1'b0;
         exc_valid <= 1'b0;
         exc_code  <= '0;
         status    <= fl_base;
         if (load) begin
            busy  <= 1'b1;
            cnt   <= CNT_W'(1);
            pre_r <= pre_c;
            ed_r  <= $signed({2'b00, dvnd_i[SP_W-2 -: EXP_W]})
                   - $signed({2'b00, dvsr_i[SP_W-2 -: EXP_W]})
                   + SE_W'(BIAS);
            sgn_r <= dvsr_i[SP_W-1] ^ dvnd_i[SP_W-1];
         end else if (busy) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt == CNT_W'(LAT)) begin
               busy      <= 1'b0;
               cnt       <= '0;
               done      <= 1'b1;
               result    <= fin_val;
               wr_en     <= !fin_exc;
               exc_valid <= fin_exc;
               exc_code  <= fin_exc ? EXC_CODE : '0;
               status    <= fl_base | fin_fl;
            end
         end
      end
   end
endmodule

// File: rtl/fpd_chk.sv
module fpd_chk
   import fpd_pkg::*;
#(
   parameter int               LAT_MODE = 0,
   parameter int               EXC_W    = 5,
   parameter logic [EXC_W-1:0] EXC_CODE = 5'b00110
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             clr_flags,
   input logic             done,
   input logic             wr_en,
   input logic             exc_valid,
   input logic [EXC_W-1:0] exc_code,
   input logic [FL_N-1:0]  status,
   input logic [SP_W-1:0]  result
);
   localparam int LAT = lat_for_mode(LAT_MODE);

   logic [7:0] since;
   always_ff @(posedge clk) begin
      if (!rst_n)              since <= '0;
      else if (start && !busy) since <= 8'd1;
      else if (done)           since <= '0;
      else if (since != '0)    since <= since + 8'd1;
   end

   // R9
   lat_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since == 8'(LAT + 1)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (done && !exc_valid));
   // R8
   exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (done && exc_code == EXC_CODE));
   // R8
   code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_code == '0));
   // R11
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_flags |=> ((status & $past(status)) == $past(status)));
   // R11
   flag_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status) |-> (done || $past(clr_flags)));
   // R12
   res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
endmodule

bind fp_quot_seq fpd_chk #(.LAT_MODE(LAT_MODE), .EXC_W(EXC_W), .EXC_CODE(EXC_CODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .clr_flags (clr_flags),
   .done      (done),
   .wr_en     (wr_en),
   .exc_valid (exc_valid),
   .exc_code  (exc_code),
   .status    (status),
   .result    (result)
);

// File: tb/sim_fp_quot_seq.sv
`timescale 1ns/1ps
module sim_fp_quot_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        clr = 1'b0;
   logic [31:0] dvsr = '0;
   logic [31:0] dvnd = '0;

   logic [31:0] res [3];
   logic        dn  [3];
   logic        we  [3];
   logic        ev  [3];
   logic [4:0]  ec  [3];
   logic [4:0]  st  [3];

   int n_chk = 0;
   int n_err = 0;
   logic [4:0] flags_exp = '0;
   localparam int LATS [3] = '{24, 28, 30};

   always #2.5 clk = ~clk;

   fp_quot_seq #(.LAT_MODE(2)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .dvsr_i(dvsr),
      .dvnd_i(dvnd), .clr_flags(clr), .done(dn[0]), .result(res[0]), .wr_en(we[0]),
      .exc_valid(ev[0]), .exc_code(ec[0]), .status(st[0]));
   fp_quot_seq #(.LAT_MODE(0)) u1 (.clk(clk), .rst_n(rst_n), .start(start), .dvsr_i(dvsr),
      .dvnd_i(dvnd), .clr_flags(clr), .done(dn[1]), .result(res[1]), .wr_en(we[1]),
      .exc_valid(ev[1]), .exc_code(ec[1]), .status(st[1]));
   fp_quot_seq #(.LAT_MODE(1)) u2 (.clk(clk), .rst_n(rst_n), .start(start), .dvsr_i(dvsr),
      .dvnd_i(dvnd), .clr_flags(clr), .done(dn[2]), .result(res[2]), .wr_en(we[2]),
      .exc_valid(ev[2]), .exc_code(ec[2]), .status(st[2]));

   task automatic chk(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s", msg);
      end
   endtask

   // Reference: {wr, exc, flags[4:0], value[31:0]}; flag bits 0 inv,1 dz,2 of,3 uf,4 den
   function automatic logic [38:0] model(input logic [31:0] a, input logic [31:0] b,
                                         output string tag);
      logic a_den, b_den, a_z, b_z, a_i, b_i, a_n, b_n, a_q, b_q, sq;
      logic [63:0] ab, bb, qb;
      logic [22:0] keep;
      logic [23:0] sum;
      logic        g, s;
      int          e;
      real         q;
      a_den = a[30:23] == 0 && a[22:0] != 0;   b_den = b[30:23] == 0 && b[22:0] != 0;
      a_z   = a[30:0] == 0;                    b_z   = b[30:0] == 0;
      a_i   = a[30:23] == 8'hFF && a[22:0] == 0; b_i = b[30:23] == 8'hFF && b[22:0] == 0;
      a_n   = a[30:23] == 8'hFF && a[22:0] != 0; b_n = b[30:23] == 8'hFF && b[22:0] != 0;
      a_q   = a_n && a[22];                    b_q   = b_n && b[22];
      sq    = a[31] ^ b[31];
      if (a_den || b_den) begin
         tag = (a_n || b_n || a_z || b_z || a_i || b_i) ? "R10,R2" : "R2,R8";
         return {1'b0, 1'b1, 5'b10000, 32'hFFC00000};
      end
      if ((a_n && !a_q) || (b_n && !b_q) || (a_z && b_z) || (a_i && b_i)) begin
         tag = (a_q || b_q) ? "R10,R3" : "R3,R8";
         return {1'b0, 1'b1, 5'b00001, 32'hFFC00000};
      end
      if (a_q || b_q) begin
         tag = "R4";
         return {1'b1, 1'b0, 5'b00000, 32'hFFC00000};
      end
      if (a_z && !b_i) begin
         tag = "R5,R8";
         return {1'b0, 1'b1, 5'b00010, sq, 8'hFF, 23'h0};
      end
      if (b_i) begin
         tag = "R13";
         return {1'b1, 1'b0, 5'b00000, sq, 8'hFF, 23'h0};
      end
      if (a_i || b_z) begin
         tag = "R13";
         return {1'b1, 1'b0, 5'b00000, sq, 31'h0};
      end
      ab = {a[31], 11'(a[30:23]) + 11'd896, a[22:0], 29'h0};
      bb = {b[31], 11'(b[30:23]) + 11'd896, b[22:0], 29'h0};
      q  = $bitstoreal(bb) / $bitstoreal(ab);
      qb = $realtobits(q);
      e  = int'(qb[62:52]) - 1023 + 127;
      keep = qb[51:29];
      g    = qb[28];
      s    = |qb[27:0];
      sum  = {1'b0, keep} + 24'(g && (s || keep[0]));
      if (sum[23]) e = e + 1;
      if (e <= 0) begin
         tag = "R6,R8";
         return {1'b0, 1'b1, 5'b01000, sq, 31'h0};
      end
      if (e >= 255) begin
         tag = "R7,R8";
         return {1'b0, 1'b1, 5'b00100, sq, 8'hFF, 23'h0};
      end
      tag = "R1";
      return {1'b1, 1'b0, 5'b00000, sq, 8'(e), sum[22:0]};
   endfunction

   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit doclr,
                         input bit poke, input string extra);
      logic [38:0] ex;
      string       tag;
      int          got [3];
      logic [31:0] gr  [3];
      logic        gw  [3], ge [3];
      logic [4:0]  gc  [3], gs [3];
      logic [4:0]  ecx;
      ex = model(a, b, tag);
      flags_exp = (doclr ? 5'b0 : flags_exp) | ex[36:32];
      ecx = ex[37] ? 5'b00110 : 5'b00000;
      for (int i = 0; i < 3; i++) got[i] = -1;
      @(negedge clk);
      dvsr = a; dvnd = b; start = 1'b1; clr = doclr;
      @(negedge clk);
      start = 1'b0; clr = 1'b0;
      for (int c = 0; c <= 33; c++) begin
         if (c > 0) @(negedge clk);
         // R12: a second start while busy must not disturb the running operation
         if (poke && c == 5) begin
            dvsr = 32'h3F800000; dvnd = 32'h40000000; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         for (int i = 0; i < 3; i++) begin
            if (dn[i] && got[i] < 0) begin
               got[i] = c; gr[i] = res[i]; gw[i] = we[i]; ge[i] = ev[i];
               gc[i] = ec[i]; gs[i] = st[i];
            end
         end
      end
      for (int i = 0; i < 3; i++) begin
         // R9
         chk(got[i] == LATS[i], $sformatf("R9%s inst%0d a=%h b=%h latency got %0d exp %0d",
             extra, i, a, b, got[i], LATS[i]));
         chk(got[i] >= 0 && {gw[i], ge[i], gc[i], gs[i], gr[i]} ==
             {ex[38], ex[37], ecx, flags_exp, ex[31:0]},
             $sformatf("%s%s inst%0d a=%h b=%h got wr=%b ev=%b code=%b st=%b res=%h exp wr=%b ev=%b code=%b st=%b res=%h",
             tag, extra, i, a, b, gw[i], ge[i], gc[i], gs[i], gr[i],
             ex[38], ex[37], ecx, flags_exp, ex[31:0]));
      end
   endtask

   function automatic logic [31:0] rnd_norm(input int lo, input int hi);
      int e;
      e = lo + int'($urandom % 32'(hi - lo + 1));
      return {1'($urandom), 8'(e), 23'($urandom)};
   endfunction

   localparam logic [31:0] PATS [13] = '{
      32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
      32'h7FA00000, 32'hFF800001, 32'h00000001, 32'h807FFFFF, 32'h3F800000,
      32'hC0600000, 32'h7F7FFFFF, 32'h00800000 };

   initial begin
      #(5.0 * 190000);
      n_err++;
      $display("FAIL watchdog expired (all requirements) got hang exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R14: reset state
      for (int i = 0; i < 3; i++)
         chk({dn[i], we[i], ev[i], ec[i], st[i], res[i]} == '0,
             $sformatf("R14 inst%0d reset got %b/%b/%b/%b/%b/%h exp all zero",
             i, dn[i], we[i], ev[i], ec[i], st[i], res[i]));

      // R10: every ordered pair of special and boundary encodings
      for (int x = 0; x < 13; x++)
         for (int y = 0; y < 13; y++)
            run_op(PATS[x], PATS[y], 1'b1, 1'b0, "");

      // R1 rounding and exponent edges
      run_op(32'h40400000, 32'h3F800000, 1'b1, 1'b0, "");
      run_op(32'h3F800001, 32'h3F7FFFFF, 1'b1, 1'b0, "");
      run_op(32'h3F7FFFFF, 32'h3F800000, 1'b1, 1'b0, "");
      // R6 just below the normal range, R7 just above it
      run_op(32'h3F800001, 32'h00800000, 1'b1, 1'b0, "");
      run_op(32'h3F000000, 32'h7F7FFFFF, 1'b1, 1'b0, "");
      run_op(32'h7F7FFFFF, 32'h00800000, 1'b1, 1'b0, "");

      for (int k = 0; k < 150; k++)
         run_op(rnd_norm(1, 254), rnd_norm(1, 254), 1'b1, 1'b0, "");
      for (int k = 0; k < 150; k++)
         run_op(rnd_norm(120, 134), rnd_norm(120, 134), 1'b1, 1'b0, "");

      // R11: bits accumulate across operations without clear
      run_op(32'h00000000, 32'h3F800000, 1'b1, 1'b0, ",R11");
      run_op(32'h3F800000, 32'h40000000, 1'b0, 1'b0, ",R11");
      run_op(32'h7F800001, 32'h40000000, 1'b0, 1'b0, ",R11");
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      flags_exp = '0;
      for (int i = 0; i < 3; i++)
         chk(st[i] == 5'b0, $sformatf("R11 inst%0d after clear got %b exp 00000", i, st[i]));

      // R12: start pulse while busy
      run_op(32'h40400000, 32'h41000000, 1'b1, 1'b1, ",R12");
      run_op(32'h3FC00000, 32'hC1200000, 1'b1, 1'b1, ",R12");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule